// File: doc/BRIEF.md
# Four-share masked AND chain

This block computes the AND of two secret bits that are each carried as four Boolean shares. No share of either operand is ever combined with all the other shares of that operand in a single cross product. Each output share is one product of two share sums, plus a linear correction built from the input shares. The four output shares XOR to the AND of the two secrets. Every output share is balanced over the sharings of a given secret pair.

The top module chains two such gates to form (x AND y) AND u. The first gate's output shares, together with the third operand's shares, can pass through a register layer before the second gate. An optional register layer also sits at the chain output. Each share is W bits wide, and every bit lane is an independent masked AND. Parameters choose whether each register layer exists. With both layers present, the intermediate shares appear after one cycle and the final shares after two.

Top module: `mand_chain`

## Requirements
- R1: Output share index 0 of a gate equals ((a2^a3)&(b1^b2)) ^ b1^b2^b3 ^ a1^a2^a3, where a and b are the gate's operand shares and share index k occupies bits [k*W +: W] of a port.
- R2: Output share index 1 equals ((a0^a2)&(b0^b3)) ^ b0^b2^b3 ^ a0^a2^a3.
- R3: Output share index 2 equals ((a1^a3)&(b0^b3)) ^ b1 ^ a1.
- R4: Output share index 3 equals ((a0^a1)&(b1^b2)) ^ b0 ^ a0.
- R5: The XOR of the four shares on z_sh equals (XOR of x shares) AND (XOR of y shares), for all 256 share combinations.
- R6: For each of the four pairs of secret values (x, y), and over the 64 sharings of that pair, every first-gate output share is 1 in exactly 32 cases.
- R7: With MID_REG=1, z_sh shows the first gate's result for the inputs presented one clock earlier. The u shares are delayed by the same register layer, so both operands of the second gate come from the same input cycle.
- R8: v_sh is the second gate applied to the z shares and the delayed u shares. Its shares XOR to x AND y AND u, and with the default parameters it appears two cycles after the inputs.
- R9: An active-high synchronous rst clears every register layer to zero. When rst is high, the reset wins over new input data arriving in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| x_sh | input | 4*W | Four shares of operand x |
| y_sh | input | 4*W | Four shares of operand y |
| u_sh | input | 4*W | Four shares of operand u |
| z_sh | output | 4*W | Shares of x AND y after the middle layer |
| v_sh | output | 4*W | Shares of (x AND y) AND u |

## Verification
Fresh input shares arrive on every cycle. Reset and new data can therefore land on the same clock edge. The bench provokes this by asserting reset while it keeps driving nonzero shares and while both register layers hold live results. It then judges at the next falling edge that z_sh and v_sh are both all zero. After reset is released, it judges that the reference queue restarts cleanly, with no stale value leaking into later comparisons.

// File: rtl/mand_pkg.sv
package mand_pkg;
   localparam int unsigned NSH = 4;
   typedef enum logic {STAGE_WIRE = 1'b0, STAGE_FLOP = 1'b1} stage_kind_e;
endpackage

// File: rtl/mand_core.sv
module mand_core
   import mand_pkg::*;
#(
   parameter int unsigned W = 1
) (
   input  logic [NSH*W-1:0] a_sh,
   input  logic [NSH*W-1:0] b_sh,
   output logic [NSH*W-1:0] c_sh
);
   logic [W-1:0] a [NSH];
   logic [W-1:0] b [NSH];
   logic [W-1:0] c [NSH];

   for (genvar k = 0; k < NSH; k++) begin : g_split
      assign a[k] = a_sh[k*W +: W];
      assign b[k] = b_sh[k*W +: W];
      assign c_sh[k*W +: W] = c[k];
   end

   always_comb begin
      c[0] = ((a[2] ^ a[3]) & (b[1] ^ b[2])) ^ b[1] ^ b[2] ^ b[3] ^ a[1] ^ a[2] ^ a[3];
      c[1] = ((a[0] ^ a[2]) & (b[0] ^ b[3])) ^ b[0] ^ b[2] ^ b[3] ^ a[0] ^ a[2] ^ a[3];
      c[2] = ((a[1] ^ a[3]) & (b[0] ^ b[3])) ^ b[1] ^ a[1];
      c[3] = ((a[0] ^ a[1]) & (b[1] ^ b[2])) ^ b[0] ^ a[0];
   end
endmodule

// File: rtl/mand_stage.sv
module mand_stage
   import mand_pkg::*;
#(
   parameter int unsigned DW   = 4,
   parameter stage_kind_e KIND = STAGE_FLOP
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [DW-1:0] d,
   output logic [DW-1:0] q
);
   if (KIND == STAGE_FLOP) begin : g_flop
      always_ff @(posedge clk) begin
         if (rst) q <= '0;
         else     q <= d;
      end
   end else begin : g_wire
      logic unused_ok;
      assign unused_ok = clk ^ rst;
      assign q = d;
   end
endmodule

// File: rtl/mand_chain.sv
module mand_chain
   import mand_pkg::*;
#(
   parameter int unsigned W       = 1,
   parameter bit          MID_REG = 1'b1,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [4*W-1:0]   x_sh,
   input  logic [4*W-1:0]   y_sh,
   input  logic [4*W-1:0]   u_sh,
   output logic [4*W-1:0]   z_sh,
   output logic [4*W-1:0]   v_sh
);
   localparam int unsigned   SW       = NSH * W;
   localparam stage_kind_e   MID_KIND = MID_REG ? STAGE_FLOP : STAGE_WIRE;
   localparam stage_kind_e   OUT_KIND = OUT_REG ? STAGE_FLOP : STAGE_WIRE;

   if (W < 1) begin : g_bad_w
      $error("mand_chain: W must be at least 1");
   end
   if (NSH != 4) begin : g_bad_nsh
      $error("mand_chain: share equations need exactly four shares");
   end

   logic [SW-1:0] g1_out;
   logic [SW-1:0] u_dly;
   logic [SW-1:0] g2_out;

   mand_core #(.W(W)) u_gate1 (
      .a_sh (x_sh),
      .b_sh (y_sh),
      .c_sh (g1_out)
   );

   mand_stage #(.DW(SW), .KIND(MID_KIND)) u_mid_z (
      .clk (clk),
      .rst (rst),
      .d   (g1_out),
      .q   (z_sh)
   );

   mand_stage #(.DW(SW), .KIND(MID_KIND)) u_mid_u (
      .clk (clk),
      .rst (rst),
      .d   (u_sh),
      .q   (u_dly)
   );

   mand_core #(.W(W)) u_gate2 (
      .a_sh (z_sh),
      .b_sh (u_dly),
      .c_sh (g2_out)
   );

   mand_stage #(.DW(SW), .KIND(OUT_KIND)) u_out (
      .clk (clk),
      .rst (rst),
      .d   (g2_out),
      .q   (v_sh)
   );
endmodule

// File: rtl/mand_chain_chk.sv
module mand_chain_chk #(
   parameter int unsigned W       = 1,
   parameter bit          MID_REG = 1'b1,
   parameter bit          OUT_REG = 1'b1
) (
   input logic           clk,
   input logic           rst,
   input logic [4*W-1:0] x_sh,
   input logic [4*W-1:0] y_sh,
   input logic [4*W-1:0] u_sh,
   input logic [4*W-1:0] z_sh,
   input logic [4*W-1:0] v_sh
);
   logic [W-1:0] xs, ys, us, zs, vs;
   logic [1:0]   live;

   always_comb begin
      xs = '0; ys = '0; us = '0; zs = '0; vs = '0;
      for (int k = 0; k < 4; k++) begin
         xs ^= x_sh[k*W +: W];
         ys ^= y_sh[k*W +: W];
         us ^= u_sh[k*W +: W];
         zs ^= z_sh[k*W +: W];
         vs ^= v_sh[k*W +: W];
      end
   end

   always_ff @(posedge clk) begin
      if (rst)               live <= 2'd0;
      else if (live != 2'd3) live <= live + 2'd1;
   end

   if (MID_REG) begin : g_mid
      p_mid_clear_r9: assert property (@(posedge clk) disable iff (rst)
         $fell(rst) |-> (z_sh == '0));
      p_mid_secret_r5: assert property (@(posedge clk) disable iff (rst)
         (live >= 2'd1) |-> (zs == $past(xs & ys)));
   end

   if (OUT_REG) begin : g_out
      p_out_clear_r9: assert property (@(posedge clk) disable iff (rst)
         $fell(rst) |-> (v_sh == '0));
   end

   if (MID_REG && OUT_REG) begin : g_lat2
      p_out_secret_r8: assert property (@(posedge clk) disable iff (rst)
         (live >= 2'd2) |-> (vs == $past(xs & ys & us, 2)));
   end else if (MID_REG || OUT_REG) begin : g_lat1
      p_out_secret_r8: assert property (@(posedge clk) disable iff (rst)
         (live >= 2'd1) |-> (vs == $past(xs & ys & us)));
   end else begin : g_lat0
      always @(posedge clk) begin
         if (!rst) p_out_secret_r8: assert (vs == (xs & ys & us));
      end
   end
endmodule

bind mand_chain mand_chain_chk #(.W(W), .MID_REG(MID_REG), .OUT_REG(OUT_REG)) u_chk (
   .clk  (clk),
   .rst  (rst),
   .x_sh (x_sh),
   .y_sh (y_sh),
   .u_sh (u_sh),
   .z_sh (z_sh),
   .v_sh (v_sh)
);

// File: tb/mand_chain_tb.sv
`timescale 1ns/100ps
module mand_chain_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] x_sh = '0, y_sh = '0, u_sh = '0;
   logic [3:0] z_sh, v_sh;

   int tests = 0;
   int fails = 0;
   bit done  = 0;

   // queue of driven stimulus: index 0 = driven one falling edge ago
   logic [3:0] hx [2];
   logic [3:0] hy [2];
   logic [3:0] hu [2];
   bit         hv [2];
   int         ones [4][4];

   always #2.5 clk = ~clk;

   mand_chain #(.W(1), .MID_REG(1'b1), .OUT_REG(1'b1)) dut_i (
      .clk (clk), .rst (rst),
      .x_sh (x_sh), .y_sh (y_sh), .u_sh (u_sh),
      .z_sh (z_sh), .v_sh (v_sh)
   );

   function automatic logic [3:0] gate_ref(input logic [3:0] a, input logic [3:0] b);
      logic [3:0] c;
      c[0] = ((a[2] ^ a[3]) & (b[1] ^ b[2])) ^ b[1] ^ b[2] ^ b[3] ^ a[1] ^ a[2] ^ a[3];
      c[1] = ((a[0] ^ a[2]) & (b[0] ^ b[3])) ^ b[0] ^ b[2] ^ b[3] ^ a[0] ^ a[2] ^ a[3];
      c[2] = ((a[1] ^ a[3]) & (b[0] ^ b[3])) ^ b[1] ^ a[1];
      c[3] = ((a[0] ^ a[1]) & (b[1] ^ b[2])) ^ b[0] ^ a[0];
      return c;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic compare_now();
      logic [3:0] em, eo;
      if (hv[0]) begin
         em = gate_ref(hx[0], hy[0]);
         chk(z_sh[0] == em[0], "R1 share0", int'(z_sh[0]), int'(em[0]));
         chk(z_sh[1] == em[1], "R2 share1", int'(z_sh[1]), int'(em[1]));
         chk(z_sh[2] == em[2], "R3 share2", int'(z_sh[2]), int'(em[2]));
         chk(z_sh[3] == em[3], "R4 share3", int'(z_sh[3]), int'(em[3]));
         chk((^z_sh) == ((^hx[0]) & (^hy[0])), "R5 R7 mid secret",
             int'(^z_sh), int'((^hx[0]) & (^hy[0])));
         ones[{^hx[0], ^hy[0]}][0] += int'(z_sh[0]);
         ones[{^hx[0], ^hy[0]}][1] += int'(z_sh[1]);
         ones[{^hx[0], ^hy[0]}][2] += int'(z_sh[2]);
         ones[{^hx[0], ^hy[0]}][3] += int'(z_sh[3]);
      end
      if (hv[1]) begin
         eo = gate_ref(gate_ref(hx[1], hy[1]), hu[1]);
         chk(v_sh == eo, "R8 out shares", int'(v_sh), int'(eo));
         chk((^v_sh) == ((^hx[1]) & (^hy[1]) & (^hu[1])), "R8 out secret",
             int'(^v_sh), int'((^hx[1]) & (^hy[1]) & (^hu[1])));
      end
   endtask

   task automatic step(input logic [3:0] x, input logic [3:0] y, input logic [3:0] u);
      @(negedge clk);
      compare_now();
      hx[1] = hx[0]; hy[1] = hy[0]; hu[1] = hu[0]; hv[1] = hv[0];
      hx[0] = x;     hy[0] = y;     hu[0] = u;     hv[0] = 1'b1;
      x_sh = x; y_sh = y; u_sh = u;
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      hv[0] = 0; hv[1] = 0;
      for (int s = 0; s < 4; s++)
         for (int k = 0; k < 4; k++) ones[s][k] = 0;

      // reset state, with nonzero data presented during reset
      x_sh = 4'hF; y_sh = 4'hA; u_sh = 4'h5;
      repeat (3) @(negedge clk);
      chk(z_sh == 4'h0, "R9 reset z", int'(z_sh), 0);
      chk(v_sh == 4'h0, "R9 reset v", int'(v_sh), 0);
      rst = 1'b0;

      // exhaustive first-gate sharings, varied third operand
      for (int i = 0; i < 256; i++)
         step(4'(i), 4'(i >> 4), 4'(i * 5 + 3));
      step(4'h0, 4'h0, 4'h0);
      step(4'h0, 4'h0, 4'h0);

      // R6: each share balanced within every secret class
      for (int s = 0; s < 4; s++)
         for (int k = 0; k < 4; k++)
            chk(ones[s][k] == 32, $sformatf("R6 class%0d share%0d", s, k), ones[s][k], 32);

      // R7/R8: hold x,y and sweep u so only the delayed u changes the result
      for (int j = 0; j < 16; j++)
         step(4'h3, 4'h9, 4'(j));

      // R9: reset lands while both layers hold data and new data arrives
      step(4'h7, 4'hE, 4'hB);
      step(4'hD, 4'h6, 4'hF);
      @(negedge clk);
      compare_now();
      rst = 1'b1;
      x_sh = 4'h7; y_sh = 4'hB; u_sh = 4'h7;
      hv[0] = 0; hv[1] = 0;
      @(negedge clk);
      chk(z_sh == 4'h0, "R9 reset beats data z", int'(z_sh), 0);
      chk(v_sh == 4'h0, "R9 reset beats data v", int'(v_sh), 0);
      rst = 1'b0;

      // resume after reset
      for (int i = 0; i < 40; i++)
         step(4'(i * 3), 4'(i * 7 + 1), 4'(i * 11 + 2));
      step(4'h0, 4'h0, 4'h0);
      step(4'h0, 4'h0, 4'h0);

      done = 1;
      summary();
      $finish;
   end
endmodule